// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR-style memory that offers fast reads within a page. The host issues single word reads with a 22-bit word address over a valid/ready handshake. The controller drives the chip-enable, output-enable and address pins and waits a programmable number of clock cycles. It then samples the 16-bit data bus and returns the word with a one-cycle response strobe.

A page is eight words long. Address bits 21:3 name the page and bits 2:0 pick the word within it. The controller records which page is open. A request into that page waits the shorter in-page count, and any other request waits the full random-access count. Software sets both counts at run time. An idle timer releases chip enable after a fixed number of quiet cycles. Releasing chip enable, and reset, forget the open page, so the next read pays the full count. Each response carries a tag that tells whether the read was served as a page hit.

Top module: `fpr_ctrl`

## Requirements
- R1: `req_ready` is high only while no read is in progress and reset is released. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the edge after the response strobe.
- R2: After the accepting edge, `mem_ce_n` and `mem_oe_n` are low and `mem_addr` equals the request address. `mem_addr` holds that value while `mem_oe_n` is low, and `mem_oe_n` is never low while `mem_ce_n` is high.
- R3: A read is a miss when no page is open or when its bits 21:3 differ from the open page. A miss raises `rsp_valid` after L clock edges counted from the accepting edge, where L is `cfg_full_wait`, or 1 if that field is 0.
- R4: A read is a hit when its bits 21:3 equal the open page. A hit raises `rsp_valid` after P edges, where P is the smaller of `cfg_page_wait` and the effective full count L, and is 1 if that minimum is 0.
- R5: `rsp_data` is the value of `mem_dq_i` sampled on the edge that raises `rsp_valid`. `rsp_hit` is 1 for a hit and 0 for a miss.
- R6: `rsp_valid` is high for exactly one cycle. `mem_oe_n` is high from the capturing edge on, and `mem_ce_n` stays low.
- R7: After IDLE_CYC consecutive edges in the idle state without an accepted request, `mem_ce_n` goes high and the open page is forgotten. A request accepted on the IDLE_CYC-th idle edge is still a hit.
- R8: While `rst_n` is low, `mem_ce_n` and `mem_oe_n` are high and `req_ready` and `rsp_valid` are low. A read in progress when reset arrives never responds, and the first read after reset is a miss.
- R9: Both wait counts are sampled on the accepting edge. Changing `cfg_full_wait` or `cfg_page_wait` during a read does not alter that read's latency.
- R10: The open page is replaced on every accepted request. An address that differs from the open page in any single bit of 21:3 is a miss, and one that differs only in bits 2:0 is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 22 | Word address of the request |
| cfg_full_wait | input | 6 | Random-access wait in cycles |
| cfg_page_wait | input | 6 | In-page wait in cycles |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_data | output | 16 | Read data |
| rsp_hit | output | 1 | Read was served as a page hit |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 22 | Memory word address |
| mem_dq_i | input | 16 | Memory data bus |

## Verification
The assertions assume that the memory bus carries defined values whenever output enable is low. They also assume that `req_valid` and the configuration inputs are never unknown once reset is released. They do not assume that the page count is at most the full count, because the design clamps it. The bench sweeps inverted and zero settings on purpose. The bench memory returns an address-derived word only while both enables are low and a fixed filler value otherwise. All stimulus changes on falling clock edges, so every input is settled at each rising edge.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RESP = 2'd2
   } fpr_state_e;

endpackage

// File: rtl/fpr_page_track.sv
module fpr_page_track #(
   parameter int ADDR_W    = 22,
   parameter int PAGE_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              open_i,
   input  logic              clear_i,
   output logic              hit_o,
   output logic              valid_o
);

   localparam int TAG_W = ADDR_W - PAGE_BITS;

   logic [TAG_W-1:0] tag_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q   <= '0;
         valid_q <= 1'b0;
      end else if (open_i) begin
         tag_q   <= addr_i[ADDR_W-1:PAGE_BITS];
         valid_q <= 1'b1;
      end else if (clear_i) begin
         valid_q <= 1'b0;
      end
   end

   assign hit_o   = valid_q && (addr_i[ADDR_W-1:PAGE_BITS] == tag_q);
   assign valid_o = valid_q;

   AST_OPEN_SETS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      open_i |=> valid_o); // R10
   AST_CLEAR_DROPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && !open_i) |=> !valid_o); // R7

endmodule

// File: rtl/fpr_wait_timer.sv
module fpr_wait_timer #(
   parameter int LAT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LAT_W-1:0] load_i,
   output logic             expire_o
);

   logic [LAT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start_i) begin
         cnt_q <= load_i;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q <= LAT_W'(1)) run_q <= 1'b0;
         else                    cnt_q <= cnt_q - LAT_W'(1);
      end
   end

   assign expire_o = run_q && (cnt_q <= LAT_W'(1));

   AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (load_i != '0)); // R3
   AST_NO_RESTART_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !run_q); // R1

endmodule

// File: rtl/fpr_idle_timer.sv
module fpr_idle_timer #(
   parameter int IDLE_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic counting_i,
   input  logic kick_i,
   output logic release_o
);

   generate
      if (IDLE_CYC == 0) begin : g_off
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, counting_i, kick_i};
         assign release_o = 1'b0;
      end else begin : g_on
         localparam int CNT_W = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             fire;

         assign fire = counting_i && !kick_i && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (!counting_i || kick_i) cnt_q <= '0;
            else if (fire)                  cnt_q <= '0;
            else                            cnt_q <= cnt_q + CNT_W'(1);
         end

         assign release_o = fire;

         AST_IDLE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST); // R7
      end
   endgenerate

endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
   import fpr_pkg::*;
#(
   parameter int ADDR_W         = 22,
   parameter int DATA_W         = 16,
   parameter int WORDS_PER_PAGE = 8,
   parameter int LAT_W          = 6,
   parameter int IDLE_CYC       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LAT_W-1:0]  cfg_full_wait,
   input  logic [LAT_W-1:0]  cfg_page_wait,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int PAGE_BITS = $clog2(WORDS_PER_PAGE);

   generate
      if (LAT_W < 5) begin : g_bad_lat
         $error("LAT_W must be at least 5");
      end
      if ((1 << PAGE_BITS) != WORDS_PER_PAGE || PAGE_BITS < 1) begin : g_bad_page
         $error("WORDS_PER_PAGE must be a power of two above 1");
      end
      if (ADDR_W <= PAGE_BITS) begin : g_bad_addr
         $error("ADDR_W must exceed the page offset width");
      end
      if (IDLE_CYC < 0) begin : g_bad_idle
         $error("IDLE_CYC must not be negative");
      end
   endgenerate

   fpr_state_e state_q;
   logic       accept;
   logic       page_hit;
   logic       page_valid;
   logic       wait_expire;
   logic       idle_release;
   logic       cur_hit_q;

   logic [LAT_W-1:0] full_eff;
   logic [LAT_W-1:0] page_min;
   logic [LAT_W-1:0] page_eff;
   logic [LAT_W-1:0] wait_sel;

   assign req_ready = rst_n && (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      full_eff = (cfg_full_wait == '0) ? LAT_W'(1) : cfg_full_wait;
      page_min = (cfg_page_wait < full_eff) ? cfg_page_wait : full_eff;
      page_eff = (page_min == '0) ? LAT_W'(1) : page_min;
      wait_sel = page_hit ? page_eff : full_eff;
   end

   fpr_page_track #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_page (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (req_addr),
      .open_i  (accept),
      .clear_i (idle_release),
      .hit_o   (page_hit),
      .valid_o (page_valid)
   );

   fpr_wait_timer #(
      .LAT_W (LAT_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (accept),
      .load_i   (wait_sel),
      .expire_o (wait_expire)
   );

   fpr_idle_timer #(
      .IDLE_CYC (IDLE_CYC)
   ) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .counting_i ((state_q == ST_IDLE) && !mem_ce_n),
      .kick_i     (accept),
      .release_o  (idle_release)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_addr  <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_hit   <= 1'b0;
         cur_hit_q <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_WAIT;
                  mem_ce_n  <= 1'b0;
                  mem_oe_n  <= 1'b0;
                  mem_addr  <= req_addr;
                  cur_hit_q <= page_hit;
               end else if (idle_release) begin
                  mem_ce_n <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (wait_expire) begin
                  rsp_data  <= mem_dq_i;
                  rsp_hit   <= cur_hit_q;
                  rsp_valid <= 1'b1;
                  mem_oe_n  <= 1'b1;
                  state_q   <= ST_RESP;
               end
            end
            ST_RESP: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R1
   AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n); // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R2
   AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n)); // R5
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R6
   AST_CE_RELEASE_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> !page_valid); // R7

endmodule

// File: tb/test_fpr_ctrl.sv
`timescale 1ns/1ps
module test_fpr_ctrl;

   localparam int AW   = 22;
   localparam int DW   = 16;
   localparam int LW   = 6;
   localparam int IDLE = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic [LW-1:0] cfg_full_wait;
   logic [LW-1:0] cfg_page_wait;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_hit;
   logic          mem_ce_n;
   logic          mem_oe_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   bit          bvalid = 0;
   logic [18:0] bpage  = '0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return a[15:0] ^ {a[21:16], a[21:12]} ^ 16'h5A3C;
   endfunction

   assign mem_dq = (!mem_ce_n && !mem_oe_n) ? word_of(mem_addr) : 16'hBEEF;

   fpr_ctrl #(.IDLE_CYC(IDLE)) i_fpr_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .cfg_full_wait (cfg_full_wait),
      .cfg_page_wait (cfg_page_wait),
      .rsp_valid     (rsp_valid),
      .rsp_data      (rsp_data),
      .rsp_hit       (rsp_hit),
      .mem_ce_n      (mem_ce_n),
      .mem_oe_n      (mem_oe_n),
      .mem_addr      (mem_addr),
      .mem_dq_i      (mem_dq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int eff_lat(input int full, input int page, input bit hit);
      int f;
      int p;
      f = (full == 0) ? 1 : full;
      p = (page < f) ? page : f;
      if (p == 0) p = 1;
      return hit ? p : f;
   endfunction

   // Called at a falling edge; returns at the falling edge where rsp_valid is seen.
   task automatic do_read(input logic [AW-1:0] addr, input bit scramble);
      bit          exp_hit;
      int          lat;
      int          cycles;
      bit          ready_bad;
      bit          addr_bad;
      logic [LW-1:0] sv_full;
      logic [LW-1:0] sv_page;
      exp_hit = bvalid && (addr[21:3] == bpage);
      lat     = eff_lat(cfg_full_wait, cfg_page_wait, exp_hit);
      sv_full = cfg_full_wait;
      sv_page = cfg_page_wait;
      req_valid = 1'b1;
      req_addr  = addr;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!mem_ce_n && !mem_oe_n, "R2", "enables after accept", {mem_ce_n, mem_oe_n}, 0);
      chk(mem_addr == addr, "R2", "address after accept", mem_addr, addr);
      if (scramble) begin
         cfg_full_wait = ~sv_full;
         cfg_page_wait = ~sv_page;
      end
      cycles    = 0;
      ready_bad = 0;
      addr_bad  = 0;
      while (!rsp_valid && cycles < 200) begin
         if (req_ready) ready_bad = 1;
         if (mem_addr != addr) addr_bad = 1;
         @(posedge clk);
         cycles++;
         @(negedge clk);
      end
      if (req_ready) ready_bad = 1;
      chk(!ready_bad, "R1", "ready low while busy", ready_bad, 0);
      chk(!addr_bad, "R2", "address held", addr_bad, 0);
      if (scramble)
         chk(cycles == lat, "R9", "latency with config changed", cycles, lat);
      else if (exp_hit)
         chk(cycles == lat, "R4", "hit latency", cycles, lat);
      else
         chk(cycles == lat, "R3", "miss latency", cycles, lat);
      chk(rsp_data == word_of(addr), "R5", "data", rsp_data, word_of(addr));
      chk(rsp_hit == exp_hit, exp_hit ? "R10" : "R3", "hit tag", rsp_hit, exp_hit);
      chk(mem_oe_n && !mem_ce_n, "R6", "oe off ce on after capture", {mem_ce_n, mem_oe_n}, 1);
      if (scramble) begin
         cfg_full_wait = sv_full;
         cfg_page_wait = sv_page;
      end
      bvalid = 1;
      bpage  = addr[21:3];
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] base;
      rst_n         = 1'b0;
      req_valid     = 1'b0;
      req_addr      = '0;
      cfg_full_wait = 6'd5;
      cfg_page_wait = 6'd2;
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n, "R8", "enables in reset", {mem_ce_n, mem_oe_n}, 3);
      chk(!req_ready && !rsp_valid, "R8", "ready/rsp in reset", {req_ready, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1", "ready when idle", req_ready, 1);

      // Sweep of wait settings, each on a fresh page: one miss, then all 8 words.
      for (int f = 0; f <= 8; f++) begin
         for (int p = 0; p <= 9; p++) begin
            cfg_full_wait = LW'(f);
            cfg_page_wait = LW'(p);
            base = {19'(f * 97 + p * 13 + 1), 3'd0};
            do_read(base | AW'((f + p) & 7), 0);
            for (int w = 0; w < 8; w++) do_read(base | AW'((w * 5 + p) & 7), 0);
         end
      end

      // Largest settings
      cfg_full_wait = 6'd63;
      cfg_page_wait = 6'd63;
      do_read(22'h3FFFF8, 0);
      do_read(22'h3FFFFF, 0);
      @(negedge clk);
      chk(!rsp_valid, "R6", "single-cycle response", rsp_valid, 0);

      // Config change during a read
      cfg_full_wait = 6'd9;
      cfg_page_wait = 6'd3;
      do_read(22'h012340, 1);
      do_read(22'h012345, 1);

      // Single-bit page distance sweep
      cfg_full_wait = 6'd7;
      cfg_page_wait = 6'd2;
      base = 22'h2AAAAA;
      for (int b = 0; b < AW; b++) begin
         do_read(base, 0);
         do_read(base ^ (AW'(1) << b), 0);
      end

      // Idle timeout boundary: still open on the last idle edge
      do_read(22'h155550, 0);
      repeat (IDLE) @(negedge clk);
      chk(!mem_ce_n, "R7", "ce held before timeout", mem_ce_n, 0);
      do_read(22'h155551, 0);
      repeat (IDLE + 1) @(negedge clk);
      chk(mem_ce_n, "R7", "ce released after timeout", mem_ce_n, 1);
      bvalid = 0;
      do_read(22'h155552, 0);

      // Reset during a read
      cfg_full_wait = 6'd12;
      req_valid = 1'b1;
      req_addr  = 22'h155553;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n     = 1'b0;
      #1;
      chk(mem_ce_n && mem_oe_n, "R8", "enables on reset", {mem_ce_n, mem_oe_n}, 3);
      chk(!req_ready && !rsp_valid, "R8", "ready/rsp on reset", {req_ready, rsp_valid}, 0);
      repeat (2) @(negedge clk);
      rst_n  = 1'b1;
      bvalid = 0;
      begin
         bit seen;
         seen = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rsp_valid) seen = 1;
         end
         chk(!seen, "R8", "aborted read silent", seen, 0);
      end
      do_read(22'h155554, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule